// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block is the control side of a byte-wide parallel NOR flash model. Every bus write reaches it as a one-cycle strobe carrying an address and a data byte. It recognises the unlock-guarded command sequences for byte program, sector erase, chip erase, identification entry and identification exit. Any write that breaks a sequence sends the decoder back to read mode.

An accepted program or erase raises a busy flag for a parameterised number of cycles. This stands in for the internal cell time. While busy is high, the block reports the operation type and the target address, and it ignores every write. When busy falls, the result is committed to a small behavioural byte array. Reads are combinational. In identification mode a read returns the identification bytes instead of array contents.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `op` is 0 (none) and `id_mode` is 0.
- R2: Unlock and command addresses are matched on `wr_addr[14:0]` only: first unlock 5555h, second unlock 2AAAh. Bits above 14 are ignored.
- R3: Byte program takes four writes: AAh@5555h, 55h@2AAAh, A0h@5555h, then the target address and data. After busy ends, the byte reads as its old value AND the written data, so bits can only be cleared.
- R4: Sector erase takes six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address inside the sector. A sector is the 4 KB range selected by `wr_addr[ADDR_W-1:12]`. The array holds addresses 0 to 0FFFh, and a read above that returns FFh.
- R5: Chip erase uses the same first five writes as sector erase, with 10h@5555h as the sixth. After busy ends, every array byte reads FFh.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `id_mode`. In this mode a read of address 0 gives BFh, address 1 gives D5h+(ADDR_W-17) (D6h by default), and any other address gives 00h.
- R7: `id_mode` clears on either of two exit forms: a single F0h write to any address while no sequence is in progress, or AAh@5555h, 55h@2AAAh, F0h@5555h.
- R8: A write that does not match the expected step returns the decoder to idle. That write is not taken as the first step of a new sequence.
- R9: While `busy` is 1, every write is ignored, including both exit forms and new command sequences.
- R10: Busy lasts PROG_CYC, SECT_CYC or CHIP_CYC cycles, counted from the clock edge that takes the final write. During busy, `op` reads 1 (program), 2 (sector) or 3 (chip erase). During busy, `tgt_addr` holds the byte address, the sector base (low 12 bits zero) or 0 for chip erase. When idle, `op` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (array or ID bytes) |
| busy | output | 1 | Internal program/erase in progress |
| op | output | 2 | Current operation: 0 none, 1 program, 2 sector, 3 chip |
| tgt_addr | output | ADDR_W | Target byte address or sector base |
| id_mode | output | 1 | Identification read mode active |

## Verification
Random byte programs use random addresses and data, and random upper bits on the unlock addresses. Repeated programs to the same bytes show that bits only clear and that the compare ignores the high bits. Directed sequences cover several cases:
- A repeated first unlock byte and a one-bit-off address tell a broken sequence apart from a restart.
- Erasing the sector just above the array and then sector 0 checks that the sector is selected by the upper address bits.
- Writing ID entry and ID exit while busy separates the write lock-out from normal decoding.
- Both exit forms are tried from ID mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PROG = 2'd1, OP_SECT = 2'd2, OP_CHIP = 2'd3} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_UNL1, ST_UNL2, ST_PDATA, ST_ERS3, ST_ERS4, ST_ERS5} seq_e;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_DAT_A  = 8'hAA;
  localparam logic [7:0]  KEY_DAT_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_IDIN   = 8'h90;
  localparam logic [7:0]  CMD_IDOUT  = 8'hF0;
  localparam logic [7:0]  MFR_CODE   = 8'hBF;
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int SECT_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              done,
  output logic              launch,
  output op_e               op_new,
  output op_e               op_q,
  output logic [ADDR_W-1:0] tgt_q,
  output logic [7:0]        dat_q,
  output logic              id_mode
);
  seq_e st_q, st_d;
  logic id_d;
  logic hit_a, hit_b, accept;
  logic [ADDR_W-1:0] tgt_d;

  assign hit_a  = (wr_addr[14:0] == KEY_ADDR_A);
  assign hit_b  = (wr_addr[14:0] == KEY_ADDR_B);
  assign accept = wr_en && !busy;

  always_comb begin
    st_d   = st_q;
    id_d   = id_mode;
    launch = 1'b0;
    op_new = OP_NONE;
    if (accept) begin
      st_d = ST_IDLE;
      case (st_q)
        ST_IDLE: begin
          if (wr_data == CMD_IDOUT) id_d = 1'b0;
          else if (hit_a && wr_data == KEY_DAT_A) st_d = ST_UNL1;
        end
        ST_UNL1: if (hit_b && wr_data == KEY_DAT_B) st_d = ST_UNL2;
        ST_UNL2: begin
          if (hit_a) begin
            case (wr_data)
              CMD_PROG:  st_d = ST_PDATA;
              CMD_ERASE: st_d = ST_ERS3;
              CMD_IDIN:  id_d = 1'b1;
              CMD_IDOUT: id_d = 1'b0;
              default:   ;
            endcase
          end
        end
        ST_PDATA: begin
          launch = 1'b1;
          op_new = OP_PROG;
        end
        ST_ERS3: if (hit_a && wr_data == KEY_DAT_A) st_d = ST_ERS4;
        ST_ERS4: if (hit_b && wr_data == KEY_DAT_B) st_d = ST_ERS5;
        ST_ERS5: begin
          if (wr_data == CMD_SECT) begin
            launch = 1'b1;
            op_new = OP_SECT;
          end else if (hit_a && wr_data == CMD_CHIP) begin
            launch = 1'b1;
            op_new = OP_CHIP;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (op_new)
      OP_PROG: tgt_d = wr_addr;
      OP_SECT: tgt_d = {wr_addr[ADDR_W-1:SECT_AW], {SECT_AW{1'b0}}};
      default: tgt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      id_mode <= 1'b0;
    end else if (accept) begin
      st_q    <= st_d;
      id_mode <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_NONE;
      tgt_q <= '0;
      dat_q <= '0;
    end else if (launch) begin
      op_q  <= op_new;
      tgt_q <= tgt_d;
      dat_q <= wr_data;
    end else if (done) begin
      op_q  <= OP_NONE;
    end
  end

  // R10
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R9
  idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st_q == ST_IDLE);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 20,
  parameter int CHIP_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  op_e  op_new,
  output logic busy,
  output logic done
);
  localparam int MAXC_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAXC   = (MAXC_A > CHIP_CYC) ? MAXC_A : CHIP_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d, dur;

  always_comb begin
    case (op_new)
      OP_SECT: dur = CW'(SECT_CYC);
      OP_CHIP: dur = CW'(CHIP_CYC);
      default: dur = CW'(PROG_CYC);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (launch)          cnt_d = dur;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  // R9
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int MEM_AW  = 12,
  parameter int SECT_AW = 12
) (
  input  logic              clk,
  input  logic              commit,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int SN_W  = ADDR_W - SECT_AW;

  logic [7:0] mem [DEPTH];
  logic       wr_in_range, rd_in_range;

  assign wr_in_range = (addr[ADDR_W-1:MEM_AW] == '0);
  assign rd_in_range = (rd_addr[ADDR_W-1:MEM_AW] == '0);

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (op == OP_CHIP ||
            (op == OP_SECT && addr[ADDR_W-1:SECT_AW] == SN_W'(i >> SECT_AW)))
          mem[i] <= 8'hFF;
      end
      if (op == OP_PROG && wr_in_range)
        mem[addr[MEM_AW-1:0]] <= mem[addr[MEM_AW-1:0]] & data;
    end
  end

  assign rd_data = rd_in_range ? mem[rd_addr[MEM_AW-1:0]] : 8'hFF;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int MEM_AW   = 12,
  parameter int SECT_AW  = 12,
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 20,
  parameter int CHIP_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              id_mode
);
  localparam logic [7:0] DEV_CODE = 8'hD5 + 8'(ADDR_W - 17);

  logic              launch, done;
  op_e               op_new, op_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [7:0]        dat_q, arr_data;

  flash_seq_decoder #(.ADDR_W(ADDR_W), .SECT_AW(SECT_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .launch(launch), .op_new(op_new), .op_q(op_q),
    .tgt_q(tgt_q), .dat_q(dat_q), .id_mode(id_mode)
  );

  flash_busy_timer #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op_new(op_new), .busy(busy), .done(done)
  );

  flash_byte_array #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .commit(done), .op(op_q), .addr(tgt_q), .data(dat_q),
    .rd_addr(rd_addr), .rd_data(arr_data)
  );

  always_comb begin
    if (!id_mode)                     rd_data = arr_data;
    else if (rd_addr == ADDR_W'(0))   rd_data = MFR_CODE;
    else if (rd_addr == ADDR_W'(1))   rd_data = DEV_CODE;
    else                              rd_data = 8'h00;
  end

  assign op       = op_q;
  assign tgt_addr = tgt_q;

  // R10
  op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> op_q == OP_NONE);

  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(id_mode));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int AW = 18, PC = 8, SC = 20, CC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, tgt_addr;
  logic [7:0]    wr_data = '0, rd_data;
  logic          busy, id_mode;
  logic [1:0]    op;

  int errors = 0, checks = 0;
  logic [7:0] model [4096];

  always #2 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .op(op),
    .tgt_addr(tgt_addr), .id_mode(id_mode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ka(logic [14:0] low);
    return {3'($urandom), low};
  endfunction

  function automatic logic [7:0] exp_rd(logic [AW-1:0] a, logic idm);
    if (idm) return (a == 0) ? 8'hBF : (a == 1) ? 8'hD6 : 8'h00;
    if (a[AW-1:12] != 0) return 8'hFF;
    return model[a[11:0]];
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic idm);
    rd_addr = a;
    #1;
    check(req, rd_data, exp_rd(a, idm));
  endtask

  task automatic wait_op(string req, int dur, logic [1:0] eop, logic [AW-1:0] etgt);
    check(req, {busy, op}, {1'b1, eop});
    check(req, tgt_addr, etgt);
    repeat (dur - 1) @(negedge clk);
    check(req, busy, 1'b1);
    @(negedge clk);
    check(req, {busy, op}, 3'b000);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d);
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'hA0);
    wr(a, d);
    if (a[AW-1:12] == 0) model[a[11:0]] = model[a[11:0]] & d;
  endtask

  task automatic erase_pre();
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'h80);
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [7:0] d;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {busy, op, id_mode}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {busy, op, id_mode}, 4'b0000);

    // R5 chip erase
    erase_pre(); wr(ka(15'h5555), 8'h10);
    wait_op("R5", CC, 2'd3, '0);
    for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
    for (int i = 0; i < 8; i++) rd_chk("R5", AW'($urandom_range(0, 4095)), 1'b0);

    // R3 R2 R10 random programs with random upper unlock bits
    for (int i = 0; i < 30; i++) begin
      a = (i % 6 == 5) ? AW'($urandom) : AW'($urandom_range(0, 4095));
      d = 8'($urandom);
      prog(a, d);
      wait_op("R3", PC, 2'd1, a);
      rd_chk("R3", a, 1'b0);
    end
    // R3 bits only clear
    prog(AW'(12'h123), 8'hF0); wait_op("R3", PC, 2'd1, AW'(12'h123));
    prog(AW'(12'h123), 8'h3C); wait_op("R3", PC, 2'd1, AW'(12'h123));
    rd_chk("R3", AW'(12'h123), 1'b0);

    // R8 abort: repeated first byte is not a restart
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55);
    wr(ka(15'h5555), 8'hA0); wr(AW'(12'h200), 8'h00);
    check("R8", busy, 1'b0);
    rd_chk("R8", AW'(12'h200), 1'b0);
    // R2 R8 one-bit-off address breaks sequence
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAB), 8'h55); wr(ka(15'h5555), 8'hA0);
    wr(AW'(12'h201), 8'h00);
    check("R2", busy, 1'b0);
    rd_chk("R2", AW'(12'h201), 1'b0);
    // R8 wrong fifth byte in erase
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'h80);
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h54); wr(ka(15'h5555), 8'h10);
    check("R8", busy, 1'b0);

    // R6 ID entry and reads
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'h90);
    check("R6", id_mode, 1'b1);
    rd_chk("R6", AW'(0), 1'b1);
    rd_chk("R6", AW'(1), 1'b1);
    rd_chk("R6", AW'(2), 1'b1);
    // R9 exit during busy ignored
    prog(AW'(12'h300), 8'h5A);
    wr(AW'($urandom), 8'hF0);
    check("R9", {busy, id_mode}, 2'b11);
    repeat (PC) @(negedge clk);
    check("R9", {busy, id_mode}, 2'b01);
    // R7 single-write exit at any address
    wr(AW'($urandom), 8'hF0);
    check("R7", id_mode, 1'b0);
    rd_chk("R3", AW'(12'h300), 1'b0);
    // R7 three-write exit
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'h90);
    check("R6", id_mode, 1'b1);
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'hF0);
    check("R7", id_mode, 1'b0);

    // R9 ID entry and new program during busy ignored
    prog(AW'(12'h400), 8'h0F);
    wr(ka(15'h5555), 8'hAA); wr(ka(15'h2AAA), 8'h55); wr(ka(15'h5555), 8'h90);
    wr(ka(15'h5555), 8'hA0);
    repeat (PC) @(negedge clk);
    check("R9", {busy, id_mode}, 2'b00);
    rd_chk("R9", AW'(12'h400), 1'b0);
    wr(AW'(12'h400), 8'h00);
    check("R9", busy, 1'b0);
    rd_chk("R9", AW'(12'h400), 1'b0);

    // R4 sector erase of sector 1 leaves array untouched
    erase_pre(); wr(AW'(18'h01ABC), 8'h30);
    wait_op("R4", SC, 2'd2, AW'(18'h01000));
    rd_chk("R4", AW'(12'h123), 1'b0);
    rd_chk("R4", AW'(12'h300), 1'b0);
    rd_chk("R4", AW'(18'h01ABC), 1'b0);
    // R4 sector 0 erase at arbitrary in-sector address
    erase_pre(); wr(AW'(12'hABC), 8'h30);
    wait_op("R4", SC, 2'd2, '0);
    for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
    rd_chk("R4", AW'(12'h123), 1'b0);
    rd_chk("R4", AW'(12'h300), 1'b0);
    rd_chk("R4", AW'(12'h400), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule